// File: doc/BRIEF.md
# Memory Controller Chip-Select Configuration Unit

This unit keeps the configuration state of an external-memory controller. Software programs it through a small word-wide register port. The unit turns that state into two things: per-chip-select decode of incoming access addresses, and the number of wait cycles that each chip select needs for reads and for writes. Signalling to the memory devices, refresh and data transfer happen elsewhere in the controller.

Each chip select has a configuration word and a timing word. The configuration word holds an enable bit, a bus width, a memory type and an 8-bit select value. The timing word supplies the fields that set the latency. The way the latency is formed depends on the memory type. After reset, chip select 0 comes up enabled and is configured from strap inputs, so the processor can boot from it before any software has run.

Top module: `mcfg_top`

## Requirements
- R1: During and after reset, the control word, the mask and every configuration and timing word except those of chip select 0 read as zero. The power-on word reads back the strap value. Chip select 0's configuration word is formed as follows: bit 0 is set to 1, bits [2:1] take strap[1:0], and bits [6:4] take {0, strap[3:2]}. Chip select 0's timing word takes a default that depends on the memory type: 0x03FFFFFF for type 2, 0x00000020 for type 0, and 0 otherwise.
- R2: The register offsets are as follows. The control word is at 0x00 and reads back all 32 bits. The power-on word is at 0x04. The mask is at 0x08 and keeps only bits [7:0]. Chip select i has its configuration word at 0x10+8i and its timing word at 0x14+8i, and both read back all 32 bits.
- R3: A write to the power-on word at 0x04 does not change its value.
- R4: A read of any other offset returns 0, and a write to it changes no register. This includes offsets with bits [1:0] non-zero, offset 0x0C, and offsets at or above 0x10+8·NUM_CS.
- R5: Chip select i hits when its configuration bit 0 is 1 and (access address[29:22] AND mask) equals configuration bits [23:16]. Address bits [31:30] and [21:0] are ignored. The decode follows the configuration registers combinationally, so a configuration write takes effect in decode from the cycle after the write.
- R6: The hit vector has at most one bit set. When several chip selects hit, the lowest index is reported.
- R7: For memory type 2 (asynchronous), read latency = T[7:0]+T[11:8] and write latency = T[15:12]+T[19:16]+T[25:20], where T is the timing word.
- R8: For memory type 0 (SDRAM), both latencies equal 3+T[5:4].
- R9: For memory type 1 (SSRAM) and type 3 (synchronous), both latencies are 2. For types 4 to 7, both latencies are 0. For every type, the valid output follows configuration bit 0.
- R10: The valid and latency outputs are registered. After a configuration or timing write at clock edge k, they still show the old values until edge k+1, and show the new values from edge k+1 on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_i | input | 32 | Power-on strap value, sampled during reset |
| reg_addr_i | input | 8 | Register byte offset |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| acc_addr_i | input | 32 | Access address to decode |
| cs_hit_o | output | 8 | One-hot chip-select hit |
| cs_valid_o | output | 8 | Per-chip-select enable (registered) |
| cs_rd_lat_o | output | 72 | Read latency, 9 bits per chip select, chip select i at [9i+8:9i] |
| cs_wr_lat_o | output | 72 | Write latency, same packing as the read latency |

## Verification
A register write and an address lookup can fall in the same cycle. A write can change a chip select's enable bit or select field while an access address that the change affects is being decoded. The bench holds the access address steady across the write cycle of a configuration word. It requires the hit vector to show the old decode during that cycle and the new decode just after the edge. The same kind of overlap is checked for the registered latency outputs. Around a timing write, their values are taken both before and after the extra edge.

// File: rtl/mcfg_pkg.sv
package mcfg_pkg;
  localparam int unsigned DW          = 32;
  localparam int unsigned EN_BIT      = 0;
  localparam int unsigned BW_LSB      = 1;
  localparam int unsigned MT_LSB      = 4;
  localparam int unsigned SEL_LSB     = 16;
  localparam int unsigned TMS_USED    = 26;

  localparam logic [2:0] MT_SDRAM = 3'd0;
  localparam logic [2:0] MT_SSRAM = 3'd1;
  localparam logic [2:0] MT_ASYNC = 3'd2;
  localparam logic [2:0] MT_SYNC  = 3'd3;

  localparam int unsigned RD_MAX = 255 + 15;
  localparam int unsigned WR_MAX = 15 + 15 + 63;

  function automatic logic [DW-1:0] tms_default(logic [2:0] mt);
    case (mt)
      MT_ASYNC: tms_default = 32'h03FF_FFFF;
      MT_SDRAM: tms_default = 32'h0000_0020;
      default:  tms_default = '0;
    endcase
  endfunction
endpackage

// File: rtl/mcfg_regs.sv
module mcfg_regs
  import mcfg_pkg::*;
#(
  parameter int unsigned NUM_CS = 8,
  parameter int unsigned AW     = 8,
  parameter int unsigned MASK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DW-1:0]     strap_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [MASK_W-1:0] mask_o,
  output logic [DW-1:0]     csc_o [NUM_CS],
  output logic [DW-1:0]     tms_o [NUM_CS],
  output logic [NUM_CS-1:0] upd_o
);
  localparam int unsigned IDX_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int unsigned PAIR_END = 16 + 8 * NUM_CS;
  localparam logic [AW-1:0] OFF_CSR   = AW'(0);
  localparam logic [AW-1:0] OFF_POC   = AW'(4);
  localparam logic [AW-1:0] OFF_MASK  = AW'(8);
  localparam logic [AW-1:0] PAIR_BASE = AW'(16);

  logic [DW-1:0]     csr_q, poc_q;
  logic [MASK_W-1:0] mask_q;
  logic [DW-1:0]     csc_q [NUM_CS];
  logic [DW-1:0]     tms_q [NUM_CS];
  logic [NUM_CS-1:0] upd_q;

  logic              aligned, pair_hit, wr_csr, wr_mask;
  logic [AW-1:0]     pair_off;
  logic [IDX_W-1:0]  pair_idx;
  logic [NUM_CS-1:0] wr_csc, wr_tms;
  logic [DW-1:0]     csc0_rst;

  assign aligned  = (addr_i[1:0] == 2'b00);
  assign pair_off = addr_i - PAIR_BASE;
  assign pair_idx = pair_off[3 +: IDX_W];
  assign pair_hit = aligned && (addr_i >= PAIR_BASE) &&
                    ({1'b0, addr_i} < (AW+1)'(PAIR_END));
  assign wr_csr   = we_i && (addr_i == OFF_CSR);
  assign wr_mask  = we_i && (addr_i == OFF_MASK);

  always_comb begin
    csc0_rst = '0;
    csc0_rst[EN_BIT]          = 1'b1;
    csc0_rst[BW_LSB +: 2]     = strap_i[1:0];
    csc0_rst[MT_LSB +: 3]     = {1'b0, strap_i[3:2]};
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign wr_csc[i] = we_i && pair_hit && (pair_idx == IDX_W'(i)) && !addr_i[2];
    assign wr_tms[i] = we_i && pair_hit && (pair_idx == IDX_W'(i)) &&  addr_i[2];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        csc_q[i] <= (i == 0) ? csc0_rst : '0;
        tms_q[i] <= (i == 0) ? tms_default({1'b0, strap_i[3:2]}) : '0;
      end else begin
        if (wr_csc[i]) csc_q[i] <= wdata_i;
        if (wr_tms[i]) tms_q[i] <= wdata_i;
      end
    end
    assign csc_o[i] = csc_q[i];
    assign tms_o[i] = tms_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_q  <= '0;
      poc_q  <= strap_i;
      mask_q <= '0;
      upd_q  <= '1;  // load latency stage once out of reset
    end else begin
      if (wr_csr)  csr_q  <= wdata_i;
      if (wr_mask) mask_q <= wdata_i[MASK_W-1:0];
      upd_q <= wr_csc | wr_tms | {NUM_CS{wr_mask}};
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFF_CSR)       rdata_o = csr_q;
    else if (addr_i == OFF_POC)  rdata_o = poc_q;
    else if (addr_i == OFF_MASK) rdata_o = DW'(mask_q);
    else if (pair_hit)
      for (int i = 0; i < NUM_CS; i++)
        if (pair_idx == IDX_W'(i)) rdata_o = addr_i[2] ? tms_q[i] : csc_q[i];
  end

  assign mask_o = mask_q;
  assign upd_o  = upd_q;

  // R3
  poc_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(poc_q));
endmodule

// File: rtl/mcfg_lat.sv
module mcfg_lat
  import mcfg_pkg::*;
#(
  parameter int unsigned LAT_W = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                upd_i,
  input  logic                en_i,
  input  logic [2:0]          mt_i,
  input  logic [TMS_USED-1:0] tms_i,
  output logic                valid_o,
  output logic [LAT_W-1:0]    rd_lat_o,
  output logic [LAT_W-1:0]    wr_lat_o
);
  logic [LAT_W-1:0] rd_d, wr_d, rd_q, wr_q;
  logic             valid_q;

  always_comb begin
    case (mt_i)
      MT_ASYNC: begin
        rd_d = LAT_W'(tms_i[7:0]) + LAT_W'(tms_i[11:8]);
        wr_d = LAT_W'(tms_i[15:12]) + LAT_W'(tms_i[19:16]) + LAT_W'(tms_i[25:20]);
      end
      MT_SDRAM: begin
        rd_d = LAT_W'(3) + LAT_W'(tms_i[5:4]);
        wr_d = rd_d;
      end
      MT_SSRAM, MT_SYNC: begin
        rd_d = LAT_W'(2);
        wr_d = LAT_W'(2);
      end
      default: begin
        rd_d = '0;
        wr_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= '0;
      wr_q    <= '0;
      valid_q <= 1'b0;
    end else if (upd_i) begin
      rd_q    <= rd_d;
      wr_q    <= wr_d;
      valid_q <= en_i;
    end
  end

  assign valid_o  = valid_q;
  assign rd_lat_o = rd_q;
  assign wr_lat_o = wr_q;

  // R7
  lat_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_q <= LAT_W'(RD_MAX)) && (wr_q <= LAT_W'(WR_MAX)));
  // R10
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (valid_q == $past(en_i)));
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(rd_q) && $stable(wr_q));
endmodule

// File: rtl/mcfg_decode.sv
module mcfg_decode #(
  parameter int unsigned NUM_CS = 8,
  parameter int unsigned MASK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MASK_W-1:0] page_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [MASK_W-1:0] sel_i [NUM_CS],
  input  logic [NUM_CS-1:0] en_i,
  output logic [NUM_CS-1:0] hit_o
);
  logic [NUM_CS-1:0] raw;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cmp
    assign raw[i] = en_i[i] && ((page_i & mask_i) == sel_i[i]);
  end

  always_comb begin
    hit_o = '0;
    for (int i = NUM_CS - 1; i >= 0; i--)
      if (raw[i]) hit_o = NUM_CS'(1) << i;
  end

  // R6
  hit_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_o));
  // R5
  hit_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o & ~en_i) == '0);
endmodule

// File: rtl/mcfg_top.sv
module mcfg_top
  import mcfg_pkg::*;
#(
  parameter int unsigned NUM_CS = 8,
  parameter int unsigned REG_AW = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MASK_W = 8,
  parameter int unsigned LAT_W  = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [31:0]             strap_i,
  input  logic [REG_AW-1:0]       reg_addr_i,
  input  logic                    reg_we_i,
  input  logic [31:0]             reg_wdata_i,
  output logic [31:0]             reg_rdata_o,
  input  logic [ADDR_W-1:0]       acc_addr_i,
  output logic [NUM_CS-1:0]       cs_hit_o,
  output logic [NUM_CS-1:0]       cs_valid_o,
  output logic [NUM_CS*LAT_W-1:0] cs_rd_lat_o,
  output logic [NUM_CS*LAT_W-1:0] cs_wr_lat_o
);
  localparam int unsigned PAGE_LSB = 22;

  logic [MASK_W-1:0] mask;
  logic [DW-1:0]     csc [NUM_CS];
  logic [DW-1:0]     tms [NUM_CS];
  logic [NUM_CS-1:0] upd, en;
  logic [MASK_W-1:0] sel [NUM_CS];
  logic [NUM_CS-1:0] unused_bits;

  mcfg_regs #(.NUM_CS(NUM_CS), .AW(REG_AW), .MASK_W(MASK_W)) u_regs (
    .clk_i, .rst_ni, .strap_i,
    .addr_i(reg_addr_i), .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .mask_o(mask), .csc_o(csc), .tms_o(tms), .upd_o(upd)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign en[i]  = csc[i][EN_BIT];
    assign sel[i] = csc[i][SEL_LSB +: MASK_W];
    assign unused_bits[i] = ^{csc[i][DW-1:SEL_LSB+MASK_W], csc[i][SEL_LSB-1:MT_LSB+3],
                              csc[i][MT_LSB-1:BW_LSB], tms[i][DW-1:TMS_USED]};

    mcfg_lat #(.LAT_W(LAT_W)) u_lat (
      .clk_i, .rst_ni,
      .upd_i(upd[i]), .en_i(en[i]), .mt_i(csc[i][MT_LSB +: 3]),
      .tms_i(tms[i][TMS_USED-1:0]),
      .valid_o(cs_valid_o[i]),
      .rd_lat_o(cs_rd_lat_o[i*LAT_W +: LAT_W]),
      .wr_lat_o(cs_wr_lat_o[i*LAT_W +: LAT_W])
    );
  end

  logic unused_ok;
  assign unused_ok = ^{unused_bits, acc_addr_i[ADDR_W-1:PAGE_LSB+MASK_W],
                       acc_addr_i[PAGE_LSB-1:0]};

  mcfg_decode #(.NUM_CS(NUM_CS), .MASK_W(MASK_W)) u_dec (
    .clk_i, .rst_ni,
    .page_i(acc_addr_i[PAGE_LSB +: MASK_W]), .mask_i(mask),
    .sel_i(sel), .en_i(en), .hit_o(cs_hit_o)
  );
endmodule

// File: tb/tb_mcfg_top.sv
module tb_mcfg_top;
  localparam int NCS = 8;
  localparam int LW  = 9;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [31:0] strap = 32'h1324_354B;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata, acc_addr = '0;
  logic [NCS-1:0] hit, valid;
  logic [NCS*LW-1:0] rd_lat, wr_lat;

  always #2.5 clk = ~clk;

  mcfg_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .strap_i(strap),
    .reg_addr_i(reg_addr), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .acc_addr_i(acc_addr),
    .cs_hit_o(hit), .cs_valid_o(valid), .cs_rd_lat_o(rd_lat), .cs_wr_lat_o(wr_lat)
  );

  typedef struct { int kind; int idx; logic [31:0] exp; string tag; } item_t;
  item_t sb[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  // kind: 0 rdata, 1 hit, 2 rd lat, 3 wr lat, 4 valid
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.kind)
        0: act = reg_rdata;
        1: act = 32'(hit);
        2: act = 32'(rd_lat[it.idx*LW +: LW]);
        3: act = 32'(wr_lat[it.idx*LW +: LW]);
        default: act = 32'(valid[it.idx]);
      endcase
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h", it.tag, it.kind, it.idx, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask
  task automatic expect_v(int kind, int idx, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask
  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    reg_addr = a; reg_we = 1'b0;
    expect_v(0, 0, exp, tag);
    step();
  endtask
  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask
  task automatic lookup(logic [31:0] a, logic [31:0] exp, string tag);
    acc_addr = a;
    expect_v(1, 0, exp, tag);
    step();
  endtask
  task automatic lat(int i, int r, int w, string tag);
    expect_v(2, i, 32'(r), tag);
    expect_v(3, i, 32'(w), tag);
    step();
  endtask
  task automatic do_reset(logic [31:0] s);
    rst_ni = 1'b0; strap = s; reg_we = 1'b0;
    step(); step();
    rst_ni = 1'b1;
    step();
  endtask
  function automatic logic [7:0] csc_a(int i); return 8'(16 + 8*i); endfunction
  function automatic logic [7:0] tms_a(int i); return 8'(20 + 8*i); endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset with async strap
    do_reset(32'h1324_354B);
    rd(8'h00, 32'h0, "R1 csr");
    rd(8'h04, 32'h1324_354B, "R1 poc");
    rd(8'h08, 32'h0, "R1 mask");
    rd(csc_a(0), 32'h27, "R1 csc0");
    rd(tms_a(0), 32'h03FF_FFFF, "R1 tms0");
    rd(csc_a(1), 32'h0, "R1 csc1");
    rd(tms_a(7), 32'h0, "R1 tms7");
    lat(0, 270, 93, "R1 R7 lat0 async default");
    expect_v(4, 0, 1, "R1 valid0"); expect_v(4, 1, 0, "R1 valid1"); step();

    // R3
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h1324_354B, "R3 poc ro");
    // R2
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, 32'h0000_00FF, "R2 mask bits");
    wr(8'h00, 32'hA5A5_0001);
    rd(8'h00, 32'hA5A5_0001, "R2 csr");
    // R4
    wr(8'h50, 32'hDEAD_BEEF);
    rd(8'h50, 32'h0, "R4 beyond range");
    wr(8'h0C, 32'hDEAD_BEEF);
    rd(8'h0C, 32'h0, "R4 hole");
    wr(8'h11, 32'hFFFF_FFFF);
    rd(8'h11, 32'h0, "R4 unaligned read");
    rd(csc_a(0), 32'h27, "R4 csc0 untouched");
    rd(8'h00, 32'hA5A5_0001, "R4 csr untouched");
    rd(8'h08, 32'h0000_00FF, "R4 mask untouched");

    // R10 + R7: async cs3
    wr(csc_a(3), 32'h0012_0021);
    expect_v(4, 3, 0, "R10 valid3 before");
    step();
    expect_v(4, 3, 1, "R10 valid3 after");
    wr(tms_a(3), 32'h0053_240A);
    expect_v(2, 3, 0, "R10 rd3 before");
    step();
    lat(3, 14, 10, "R7 async cs3");
    rd(tms_a(3), 32'h0053_240A, "R2 tms3");
    // R8
    wr(csc_a(5), 32'h0012_0001);
    wr(tms_a(5), 32'h0000_0030);
    step();
    lat(5, 6, 6, "R8 sdram cs5");
    rd(csc_a(5), 32'h0012_0001, "R2 csc5");
    // R9
    wr(csc_a(6), 32'h0000_0011);
    wr(tms_a(6), 32'hFFFF_FFFF);
    step();
    lat(6, 2, 2, "R9 ssram cs6");
    wr(csc_a(7), 32'h0000_0031);
    step();
    lat(7, 2, 2, "R9 sync cs7");
    wr(csc_a(2), 32'h0000_0051);
    step();
    lat(2, 0, 0, "R9 other type cs2");
    expect_v(4, 2, 1, "R9 valid cs2"); step();

    // R5 R6 decode
    lookup(32'h0000_0000, 32'h01, "R6 lowest of 0,2,6,7");
    lookup(32'h0480_0000, 32'h08, "R6 cs3 over cs5");
    lookup(32'hC480_0000, 32'h08, "R5 top bits ignored");
    lookup(32'h0480_0000 | 32'h003F_FFFF, 32'h08, "R5 low bits ignored");
    wr(8'h08, 32'h0000_000F);
    lookup(32'h3C80_0000, 32'h00, "R5 masked miss");
    lookup(32'h0400_0000, 32'h01, "R5 masked hit cs0");
    wr(8'h08, 32'h0000_00FF);
    lookup(32'h0140_0000, 32'h00, "R5 no select match");
    // R5 same-cycle write and lookup
    acc_addr = 32'h0480_0000;
    reg_addr = csc_a(3); reg_we = 1'b1; reg_wdata = 32'h0012_0020;
    expect_v(1, 0, 32'h08, "R5 old decode during write");
    step();
    reg_we = 1'b0;
    expect_v(1, 0, 32'h20, "R5 new decode after write");
    step();

    // R1 reset with sdram strap
    do_reset(32'h0000_0001);
    rd(csc_a(0), 32'h03, "R1 csc0 sdram");
    rd(tms_a(0), 32'h20, "R1 tms0 sdram");
    rd(csc_a(3), 32'h0, "R1 csc3 cleared");
    rd(8'h08, 32'h0, "R1 mask cleared");
    rd(8'h00, 32'h0, "R1 csr cleared");
    lat(0, 5, 5, "R8 lat0 sdram default");
    expect_v(4, 3, 0, "R1 valid3 cleared"); step();

    // R1 reset with ssram strap
    do_reset(32'h0000_0004);
    rd(csc_a(0), 32'h11, "R1 csc0 ssram");
    rd(tms_a(0), 32'h0, "R1 tms0 ssram");
    lat(0, 2, 2, "R9 lat0 ssram");

    step();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule